// File: doc/BRIEF.md
# External Interrupt Trap Controller

This block manages one external interrupt line for a small pipelined core that runs in machine mode. It holds the interrupt-related machine CSR state: the global enable bit of `mstatus`, the external enable bit of `mie`, the external pending bit of `mip`, the trap base in `mtvec` and the return address in `mepc`. When a request is present and both enables are set, `trap_take` goes high in that cycle. The pipeline lets the execute-stage instruction retire, squashes the decode-stage instruction and branches to `trap_target`. On the clock edge that ends that cycle, the decode PC is saved to `mepc` and the global enable is cleared. An `mret` strobe sets the global enable again.

Two compile-time parameters pick the variant. `EDGE_MODE` chooses between a raw level request and a latched rising-edge request. `VECTORED` takes the trap address from an external controller port instead of `mtvec`. Every pin is a plain control or status signal, so no valid/ready handshake is used. A CSR write lands on the next clock edge. Reads and the redirect outputs are combinational.

Top module: `ext_irq_trap`

## Requirements
- R1: After reset, every CSR listed in R11 reads 0, `trap_take` is 0, the edge latch is clear and the previous-sample register of the edge detector is 0.
- R2: `trap_take` is 1 only when a request is present, `mstatus` bit 3 is 1 and `mie` bit 11 is 1.
- R3: With `VECTORED=0`, `trap_target` equals `mtvec` with its two low bits forced to 0.
- R4: With `VECTORED=1`, `trap_target` equals `ext_vec_addr`.
- R5: In a cycle with `trap_take` high, the next clock edge loads `dec_pc` into `mepc` and clears `mstatus` bit 3. As a result, `trap_take` is never high in two consecutive cycles.
- R6: `mret` high sets `mstatus` bit 3 to 1 on the next edge. `trap_take` stays 0 in any cycle where `mret` is high.
- R7: With `EDGE_MODE=0`, the request is the raw `irq_in` level and `mip` bit 11 reads that level. A source still high when interrupts are re-enabled is taken again.
- R8: With `EDGE_MODE=1`, a 0-to-1 change of `irq_in` sets a pending latch, so a one-cycle pulse is enough. The latch is set whatever the enable bits are, it is kept until `mret`, it reads as `mip` bit 11, and it is serviced as soon as both enables are 1.
- R9: With `EDGE_MODE=1`, an `irq_in` held high creates no new request after `mret`. The line must be low for at least one cycle before the next edge.
- R10: When a new edge and `mret` occur in the same cycle, the pending latch stays set.
- R11: CSR map: `mstatus` is 0x300 (enable at bit 3), `mie` is 0x304 (bit 11), `mtvec` is 0x305, `mepc` is 0x341 and `mip` is 0x344 (bit 11). Writes to `mip` have no effect. `mtvec` bits 1:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | External interrupt line |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| dec_pc | input | XLEN | PC of the decode-stage instruction |
| mret | input | 1 | MRET executes this cycle |
| ext_vec_addr | input | XLEN | Trap address from an external controller |
| trap_take | output | 1 | Squash decode and redirect this cycle |
| trap_target | output | XLEN | Redirect address |

## Verification
Two events can land in the same cycle. The first pair is a new rising edge and `mret`. The bench drives both on the same falling clock edge while a handler is in progress. It then expects `trap_take` to stay low in that cycle and to rise in the next cycle, because the latch survived. The second pair is `mret` and a level request that would otherwise be taken. The bench raises the level line together with `mret` while both enables are set. It expects no trap in the `mret` cycle and a trap in the cycle after.

// File: rtl/ext_irq_trap_pkg.sv
package ext_irq_trap_pkg;
  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_MIE     = 12'h304;
  localparam logic [11:0] CSR_MTVEC   = 12'h305;
  localparam logic [11:0] CSR_MEPC    = 12'h341;
  localparam logic [11:0] CSR_MIP     = 12'h344;
  localparam int GIE_BIT = 3;
  localparam int EXT_BIT = 11;
endpackage

// File: rtl/irq_source.sv
module irq_source #(
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic mret,
  output logic req
);
  generate
    if (EDGE_MODE) begin : g_edge
      logic prev_q;
      logic pend_q;
      logic rise;

      assign rise = irq_in & ~prev_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= irq_in;
          if (rise)      pend_q <= 1'b1;
          else if (mret) pend_q <= 1'b0;
        end
      end

      assign req = pend_q;

      // R8
      edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && !prev_q) |=> req);
      // R8
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !mret) |=> req);
      // R10
      edge_beats_mret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && !prev_q && mret) |=> req);
      // R9
      held_no_relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && prev_q && irq_in) |=> !req);
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{clk, rst_n, mret};
      assign req = irq_in;
    end
  endgenerate
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import ext_irq_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  input  logic            take,
  input  logic            mret,
  input  logic [XLEN-1:0] dec_pc,
  input  logic            pend_view,
  output logic            gie,
  output logic            meie,
  output logic [XLEN-1:0] mtvec_base
);
  localparam int BASE_W = XLEN - 2;

  logic [BASE_W-1:0] base_q;
  logic [XLEN-1:0]   mepc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie    <= 1'b0;
      meie   <= 1'b0;
      base_q <= '0;
      mepc_q <= '0;
    end else begin
      if (take)                              gie <= 1'b0;
      else if (mret)                         gie <= 1'b1;
      else if (we && addr == CSR_MSTATUS)    gie <= wdata[GIE_BIT];
      if (we && addr == CSR_MIE)             meie <= wdata[EXT_BIT];
      if (we && addr == CSR_MTVEC)           base_q <= wdata[XLEN-1:2];
      if (take)                              mepc_q <= dec_pc;
      else if (we && addr == CSR_MEPC)       mepc_q <= wdata;
    end
  end

  assign mtvec_base = {base_q, 2'b00};

  always_comb begin
    rdata = '0;
    case (addr)
      CSR_MSTATUS: rdata[GIE_BIT] = gie;
      CSR_MIE:     rdata[EXT_BIT] = meie;
      CSR_MIP:     rdata[EXT_BIT] = pend_view;
      CSR_MTVEC:   rdata = mtvec_base;
      CSR_MEPC:    rdata = mepc_q;
      default:     rdata = '0;
    endcase
  end

  // R5
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);
  // R5
  take_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mepc_q == $past(dec_pc)));
  // R6
  mret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !take) |=> gie);
endmodule

// File: rtl/ext_irq_trap.sv
module ext_irq_trap
  import ext_irq_trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit EDGE_MODE = 1'b1,
  parameter bit VECTORED  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_in,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] dec_pc,
  input  logic            mret,
  input  logic [XLEN-1:0] ext_vec_addr,
  output logic            trap_take,
  output logic [XLEN-1:0] trap_target
);
  logic            req;
  logic            gie;
  logic            meie;
  logic [XLEN-1:0] mtvec_base;

  irq_source #(.EDGE_MODE(EDGE_MODE)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .mret   (mret),
    .req    (req)
  );

  irq_csr_regs #(.XLEN(XLEN)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (csr_we),
    .addr       (csr_addr),
    .wdata      (csr_wdata),
    .rdata      (csr_rdata),
    .take       (trap_take),
    .mret       (mret),
    .dec_pc     (dec_pc),
    .pend_view  (req),
    .gie        (gie),
    .meie       (meie),
    .mtvec_base (mtvec_base)
  );

  assign trap_take = req & gie & meie & ~mret;

  generate
    if (VECTORED) begin : g_vec
      assign trap_target = ext_vec_addr;
    end else begin : g_base
      logic unused_vec;
      assign unused_vec = ^ext_vec_addr;
      assign trap_target = mtvec_base;
    end
  endgenerate

  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !trap_take);
endmodule

// File: tb/test_ext_irq_trap.sv
`timescale 1ns/100ps
module test_ext_irq_trap;
  import ext_irq_trap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_e = 1'b0, irq_l = 1'b0;
  logic        we_e = 1'b0, we_l = 1'b0;
  logic        mret_e = 1'b0, mret_l = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] dec_pc = '0;
  logic [31:0] ext_vec = '0;
  logic [31:0] rdata_e, rdata_l, target_e, target_l;
  logic        take_e, take_l;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ext_irq_trap #(.XLEN(32), .EDGE_MODE(1'b1), .VECTORED(1'b1)) i_ext_irq_trap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_e), .csr_we(we_e), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_e), .dec_pc(dec_pc), .mret(mret_e),
    .ext_vec_addr(ext_vec), .trap_take(take_e), .trap_target(target_e));

  ext_irq_trap #(.XLEN(32), .EDGE_MODE(1'b0), .VECTORED(1'b0)) i_ext_irq_trap_lvl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_l), .csr_we(we_l), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_l), .dec_pc(dec_pc), .mret(mret_l),
    .ext_vec_addr(ext_vec), .trap_take(take_l), .trap_target(target_l));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit lvl, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d;
    if (lvl) we_l = 1'b1; else we_e = 1'b1;
    @(negedge clk);
    we_l = 1'b0; we_e = 1'b0;
  endtask

  task automatic rd_chk(input bit lvl, input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(req, lvl ? rdata_l : rdata_e, exp);
  endtask

  task automatic pulse_mret(input bit lvl);
    @(negedge clk);
    if (lvl) mret_l = 1'b1; else mret_e = 1'b1;
    @(negedge clk);
    mret_l = 1'b0; mret_e = 1'b0;
  endtask

  task automatic t_reset;
    logic [11:0] addrs [5] = '{CSR_MSTATUS, CSR_MIE, CSR_MIP, CSR_MTVEC, CSR_MEPC};
    chk("R1 take_e", {31'b0, take_e}, 32'd0);
    chk("R1 take_l", {31'b0, take_l}, 32'd0);
    foreach (addrs[i]) begin
      rd_chk(1'b0, addrs[i], 32'd0, "R1 edge csr");
      rd_chk(1'b1, addrs[i], 32'd0, "R1 level csr");
    end
  endtask

  task automatic t_csr_fields;
    wr(1'b0, CSR_MTVEC, 32'h8000_0103);
    rd_chk(1'b0, CSR_MTVEC, 32'h8000_0100, "R11 mtvec low bits");
    wr(1'b0, CSR_MIP, 32'h0000_0800);
    rd_chk(1'b0, CSR_MIP, 32'd0, "R11 mip write ignored");
    wr(1'b0, CSR_MEPC, 32'h0000_0055);
    rd_chk(1'b0, CSR_MEPC, 32'h0000_0055, "R11 mepc rw");
    wr(1'b0, CSR_MIE, 32'h0000_0800);
    rd_chk(1'b0, CSR_MIE, 32'h0000_0800, "R11 mie bit11");
  endtask

  task automatic t_edge_masked;
    dec_pc = 32'h0000_1234; ext_vec = 32'h0000_4440;
    @(negedge clk); irq_e = 1'b1;
    @(negedge clk); irq_e = 1'b0;
    #1 chk("R2 no take while gie=0", {31'b0, take_e}, 32'd0);
    rd_chk(1'b0, CSR_MIP, 32'h0000_0800, "R8 latched while disabled");
    wr(1'b0, CSR_MSTATUS, 32'h0000_0008);
    #1;
    chk("R8 serviced on enable", {31'b0, take_e}, 32'd1);
    chk("R4 vectored target", target_e, 32'h0000_4440);
    @(negedge clk); #1;
    chk("R5 single-cycle take", {31'b0, take_e}, 32'd0);
    rd_chk(1'b0, CSR_MEPC, 32'h0000_1234, "R5 mepc saved");
    rd_chk(1'b0, CSR_MSTATUS, 32'd0, "R5 gie cleared");
    rd_chk(1'b0, CSR_MIP, 32'h0000_0800, "R8 pending until mret");
  endtask

  task automatic t_edge_mret_same;
    dec_pc = 32'h0000_2000;
    @(negedge clk); irq_e = 1'b1; mret_e = 1'b1;
    #1 chk("R6 no take in mret cycle", {31'b0, take_e}, 32'd0);
    @(negedge clk); mret_e = 1'b0;
    #1 chk("R10 edge survives mret", {31'b0, take_e}, 32'd1);
    @(negedge clk);
    rd_chk(1'b0, CSR_MEPC, 32'h0000_2000, "R5 mepc second trap");
  endtask

  task automatic t_edge_held;
    pulse_mret(1'b0);
    #1 chk("R9 held high no retrigger", {31'b0, take_e}, 32'd0);
    rd_chk(1'b0, CSR_MIP, 32'd0, "R9 pending cleared by mret");
    rd_chk(1'b0, CSR_MSTATUS, 32'h0000_0008, "R6 mret sets gie");
    @(negedge clk); irq_e = 1'b0;
    @(negedge clk); irq_e = 1'b1;
    @(negedge clk);
    #1 chk("R8 new edge after low cycle", {31'b0, take_e}, 32'd1);
    @(negedge clk); irq_e = 1'b0;
    pulse_mret(1'b0);
  endtask

  task automatic t_meie_gate;
    wr(1'b0, CSR_MIE, 32'd0);
    @(negedge clk); irq_e = 1'b1;
    @(negedge clk); irq_e = 1'b0;
    #1 chk("R2 no take while meie=0", {31'b0, take_e}, 32'd0);
    wr(1'b0, CSR_MIE, 32'h0000_0800);
    #1 chk("R2 take once meie=1", {31'b0, take_e}, 32'd1);
    pulse_mret(1'b0);
  endtask

  task automatic t_level;
    wr(1'b1, CSR_MTVEC, 32'h0000_0301);
    wr(1'b1, CSR_MIE, 32'h0000_0800);
    wr(1'b1, CSR_MSTATUS, 32'h0000_0008);
    dec_pc = 32'h0000_3000;
    @(negedge clk); irq_l = 1'b1; mret_l = 1'b1;
    #1 chk("R6 level blocked by mret", {31'b0, take_l}, 32'd0);
    @(negedge clk); mret_l = 1'b0;
    #1;
    chk("R7 level take", {31'b0, take_l}, 32'd1);
    chk("R3 mtvec target", target_l, 32'h0000_0300);
    @(negedge clk);
    #1 chk("R5 level no back-to-back", {31'b0, take_l}, 32'd0);
    rd_chk(1'b1, CSR_MEPC, 32'h0000_3000, "R5 level mepc");
    rd_chk(1'b1, CSR_MIP, 32'h0000_0800, "R7 mip raw level high");
    pulse_mret(1'b1);
    #1 chk("R7 retaken while still high", {31'b0, take_l}, 32'd1);
    @(negedge clk); irq_l = 1'b0;
    rd_chk(1'b1, CSR_MIP, 32'd0, "R7 mip raw level low");
    pulse_mret(1'b1);
    #1 chk("R7 no take after source low", {31'b0, take_l}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr_fields();
    t_edge_masked();
    t_edge_mret_same();
    t_edge_held();
    t_meie_gate();
    t_level();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule